// File: doc/BRIEF.md
# Embedded-sync 4:2:2 video byte decoder

This block takes an 8-bit 4:2:2 component video stream, one byte per clock, and turns it back into pixels and timing. Sync is not carried on separate wires. It is signalled by timing codes inside the byte stream. A timing code is the three bytes FF, 00, 00 followed by a code byte. The code byte carries the field, vertical-blanking and horizontal-position flags, together with four protection bits. The block checks those protection bits and drops any code that fails.

Between a start-of-active-video code and the next end-of-active-video code on an active line, the incoming samples are chroma-blue, luma, chroma-red, luma, and this order repeats. The block outputs one Y/Cb/Cr pixel for each luma sample. The two luma samples of a group share the chroma pair of that group. The field, vertical-blanking and horizontal-blanking flags sit next to the pixel outputs. A downstream scaler or frame writer can therefore frame the pixels without decoding the stream again.

Top module: `vid_stream_decoder`

## Requirements
- R1: After reset `fieldId` is 0, `vBlank` and `hBlank` are 1, and `pixValid` and `codeErr` are 0.
- R2: The bytes FF, 00, 00 followed by a code byte form a timing code. In the code byte, bit 6 is the field, bit 5 is vertical blanking and bit 4 is H, where H is 0 at the start of active video and 1 at the end. These three bits appear on `fieldId`, `vBlank` and `hBlank` in the cycle after the code byte is sampled.
- R3: A code byte is accepted only if bit 7 is 1 and bits 3..0 equal V^H, F^H, F^V and F^V^H, in that order. A code byte that fails this check makes `codeErr` high for exactly one cycle. It leaves the flags and the sample phase unchanged.
- R4: After an accepted code with H=0 and V=0, data bytes are taken as Cb, Y0, Cr, Y1, and this order repeats. The pixel (Y0,Cb,Cr) is output in the cycle after the Cr byte. The pixel (Y1,Cb,Cr) is output in the cycle after the Y1 byte.
- R5: `pixValid` is high once per luma sample, and only between an accepted start-of-active code with V=0 and the next accepted code. Bytes outside that window and the code bytes themselves produce no pixel.
- R6: An accepted start-of-active code with V=1 produces no pixels on that line.
- R7: An accepted end-of-active code drops an incomplete chroma group, and no pixel is output for its pending luma. The next line restarts at Cb.
- R8: Inside active video, the bytes 00 and FF are not samples. They neither advance the sample order nor produce a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate clock |
| rstN | input | 1 | Active-low synchronous reset |
| vidByte | input | 8 | Incoming stream byte, one per clock |
| pixY | output | 8 | Luma of the output pixel |
| pixCb | output | 8 | Blue chroma of the output pixel |
| pixCr | output | 8 | Red chroma of the output pixel |
| pixValid | output | 1 | Pixel outputs carry a new pixel this cycle |
| fieldId | output | 1 | Field flag from the last accepted code |
| vBlank | output | 1 | Vertical-blanking flag from the last accepted code |
| hBlank | output | 1 | Horizontal flag from the last accepted code |
| codeErr | output | 1 | One-cycle pulse after a code byte fails its protection check |

## Verification
Two cases are hard to reach. The first is a corrupted timing code arriving in the middle of an active line. The second is an end-of-active code that cuts a chroma group short. In both, the sample phase must survive or be reset exactly at the code byte. A correct line never produces either case. The stimulus therefore builds lines byte by byte. It inserts a bad code between Y0 and Cr, ends one line after Cb and Y0, and places reserved 00 and FF bytes in the middle of chroma groups. A behavioural model walks the same bytes and is compared against the outputs on every clock.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic take;     // current byte is a video sample
    logic restart;  // accepted timing code: restart the sample order
  } ctlStrobe_t;

  // Position inside the four-byte chroma/luma group.
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } samplePhase_t;

endpackage

// File: rtl/vsd_ctrl.sv
module vsd_ctrl
  import vsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  output ctlStrobe_t        strobe,
  output logic              fieldQ,
  output logic              vblankQ,
  output logic              hblankQ,
  output logic              errQ
);

  localparam int PRE_LEN  = 3;
  localparam int MARK_POS = BYTE_W - 1;
  localparam int F_POS    = BYTE_W - 2;
  localparam int V_POS    = BYTE_W - 3;
  localparam int H_POS    = BYTE_W - 4;

  // hist[0] holds the newest byte and hist[PRE_LEN-1] the oldest.
  logic [BYTE_W-1:0] hist [PRE_LEN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
    end else begin
      hist[0] <= byteIn;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  // Preamble match: the oldest byte must be all ones, the later ones all zeros.
  logic [PRE_LEN-1:0] preHit;
  generate
    for (genvar g = 0; g < PRE_LEN; g++) begin : gPre
      if (g == PRE_LEN - 1) begin : gOnes
        assign preHit[g] = (hist[g] == '1);
      end else begin : gZeros
        assign preHit[g] = (hist[g] == '0);
      end
    end
  endgenerate

  logic codeSeen, fBit, vBit, hBit, markOk, protOk, codeGood, codeBad;
  logic [3:0] protExp;
  logic isReserved;
  logic activeQ;

  always_comb begin
    codeSeen = &preHit;
    fBit     = byteIn[F_POS];
    vBit     = byteIn[V_POS];
    hBit     = byteIn[H_POS];
    markOk   = byteIn[MARK_POS];
    protExp  = {vBit ^ hBit, fBit ^ hBit, fBit ^ vBit, fBit ^ vBit ^ hBit};
    protOk   = (byteIn[3:0] == protExp);
    codeGood = codeSeen && markOk && protOk;
    codeBad  = codeSeen && !(markOk && protOk);
    isReserved = (byteIn == '0) || (byteIn == '1);
    strobe.take    = activeQ && !codeSeen && !isReserved;
    strobe.restart = codeGood;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldQ  <= 1'b0;
      vblankQ <= 1'b1;
      hblankQ <= 1'b1;
      activeQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      errQ <= codeBad;
      if (codeGood) begin
        fieldQ  <= fBit;
        vblankQ <= vBit;
        hblankQ <= hBit;
        activeQ <= !vBit && !hBit;
      end
    end
  end

  // R3: a rejected code leaves every flag as it was.
  a_r3_err_keeps_flags: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> ($stable(fieldQ) && $stable(vblankQ) && $stable(hblankQ)));

  // R3: a preamble takes three bytes, so the error is never longer than one cycle.
  a_r3_err_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> !errQ);

  // R5: the sample window is open only while both flags show active video.
  a_r5_active_open: assert property (@(posedge clk) disable iff (!rstN)
    activeQ |-> (!vblankQ && !hblankQ));

endmodule

// File: rtl/vsd_dp.sv
module vsd_dp
  import vsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  ctlStrobe_t        strobe,
  output logic [BYTE_W-1:0] pixY,
  output logic [BYTE_W-1:0] pixCb,
  output logic [BYTE_W-1:0] pixCr,
  output logic              pixValid
);

  samplePhase_t      phase;
  logic [BYTE_W-1:0] cbHold, crHold, y0Hold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_CB;
      cbHold   <= '0;
      crHold   <= '0;
      y0Hold   <= '0;
      pixY     <= '0;
      pixCb    <= '0;
      pixCr    <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= 1'b0;
      if (strobe.restart) begin
        phase <= PH_CB;
      end else if (strobe.take) begin
        unique case (phase)
          PH_CB: begin
            cbHold <= byteIn;
            phase  <= PH_Y0;
          end
          PH_Y0: begin
            y0Hold <= byteIn;
            phase  <= PH_CR;
          end
          PH_CR: begin
            crHold   <= byteIn;
            pixY     <= y0Hold;
            pixCb    <= cbHold;
            pixCr    <= byteIn;
            pixValid <= 1'b1;
            phase    <= PH_Y1;
          end
          PH_Y1: begin
            pixY     <= byteIn;
            pixCb    <= cbHold;
            pixCr    <= crHold;
            pixValid <= 1'b1;
            phase    <= PH_CB;
          end
          default: phase <= PH_CB;
        endcase
      end
    end
  end

  // R4: two back-to-back pixels are the two halves of one group and share chroma.
  a_r4_pair_shares_chroma: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $past(pixValid)) |-> ($stable(pixCb) && $stable(pixCr)));

  // R8: a reserved value never comes out as luma.
  a_r8_no_reserved_luma: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (pixY != '0 && pixY != '1));

endmodule

// File: rtl/vid_stream_decoder.sv
module vid_stream_decoder
  import vsd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] vidByte,
  output logic [BYTE_W-1:0] pixY,
  output logic [BYTE_W-1:0] pixCb,
  output logic [BYTE_W-1:0] pixCr,
  output logic              pixValid,
  output logic              fieldId,
  output logic              vBlank,
  output logic              hBlank,
  output logic              codeErr
);

  ctlStrobe_t strobe;

  vsd_ctrl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .byteIn  (vidByte),
    .strobe  (strobe),
    .fieldQ  (fieldId),
    .vblankQ (vBlank),
    .hblankQ (hBlank),
    .errQ    (codeErr)
  );

  vsd_dp #(.BYTE_W(BYTE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .byteIn   (vidByte),
    .strobe   (strobe),
    .pixY     (pixY),
    .pixCb    (pixCb),
    .pixCr    (pixCr),
    .pixValid (pixValid)
  );

  // R5: pixels appear only while the flags report active video.
  a_r5_pixels_in_active: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> (!vBlank && !hBlank));

endmodule

// File: tb/sim_vid_stream_decoder.sv
module sim_vid_stream_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] vidByte = 8'h00;
  logic [7:0] pixY, pixCb, pixCr;
  logic       pixValid, fieldId, vBlank, hBlank, codeErr;

  always #2.5 clk = ~clk;

  vid_stream_decoder u0 (
    .clk(clk), .rstN(rstN), .vidByte(vidByte),
    .pixY(pixY), .pixCb(pixCb), .pixCr(pixCr), .pixValid(pixValid),
    .fieldId(fieldId), .vBlank(vBlank), .hBlank(hBlank), .codeErr(codeErr)
  );

  int checks = 0;
  int errors = 0;
  int pixCount = 0;
  int errCount = 0;
  bit done = 0;

  // Behavioural model state.
  int         hist[$];
  bit         mF = 0, mV = 1, mH = 1, mAct = 0;
  int         mPh = 0;
  logic [7:0] mCb = 0, mCr = 0, mY0 = 0;
  bit         eValid = 0, eErr = 0;
  logic [7:0] eY = 0, eCb = 0, eCr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(pixValid == eValid, "R5", "pixValid", pixValid, eValid);
    check(codeErr == eErr, "R3", "codeErr", codeErr, eErr);
    check(fieldId == mF, "R2", "fieldId", fieldId, mF);
    check(vBlank == mV, "R2", "vBlank", vBlank, mV);
    check(hBlank == mH, "R2", "hBlank", hBlank, mH);
    if (eValid && pixValid) begin
      check(pixY == eY, "R4", "pixY", pixY, eY);
      check(pixCb == eCb, "R4", "pixCb", pixCb, eCb);
      check(pixCr == eCr, "R4", "pixCr", pixCr, eCr);
    end
    if (pixValid) pixCount++;
    if (codeErr) errCount++;
  endtask

  function automatic bit protGood(input logic [7:0] c);
    bit f, v, h;
    f = c[6]; v = c[5]; h = c[4];
    return c[7] && (c[3] == (v ^ h)) && (c[2] == (f ^ h)) &&
           (c[1] == (f ^ v)) && (c[0] == (f ^ v ^ h));
  endfunction

  task automatic modelStep(input logic [7:0] b);
    bit isCode;
    eValid = 0;
    eErr = 0;
    isCode = (hist.size() == 3) && (hist[0] == 8'hFF) && (hist[1] == 0) && (hist[2] == 0);
    if (isCode) begin
      if (protGood(b)) begin
        mF = b[6]; mV = b[5]; mH = b[4];
        mAct = !b[5] && !b[4];
        mPh = 0;
      end else begin
        eErr = 1;
      end
    end else if (mAct && b != 8'h00 && b != 8'hFF) begin
      case (mPh)
        0: mCb = b;
        1: mY0 = b;
        2: begin mCr = b; eY = mY0; eCb = mCb; eCr = b; eValid = 1; end
        default: begin eY = b; eCb = mCb; eCr = mCr; eValid = 1; end
      endcase
      mPh = (mPh + 1) % 4;
    end
    hist.push_back(int'(b));
    if (hist.size() > 3) void'(hist.pop_front());
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    compareAll();
    vidByte = b;
    modelStep(b);
  endtask

  task automatic sendCode(input logic [7:0] c);
    sendByte(8'hFF); sendByte(8'h00); sendByte(8'h00); sendByte(c);
  endtask

  task automatic sendGroups(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      sendByte(8'(8'h40 + seed + i));
      sendByte(8'(8'h20 + seed + 2 * i));
      sendByte(8'(8'hA0 + seed + i));
      sendByte(8'(8'h21 + seed + 2 * i));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendByte(8'h10);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(fieldId == 0, "R1", "fieldId", fieldId, 0);
    check(vBlank == 1, "R1", "vBlank", vBlank, 1);
    check(hBlank == 1, "R1", "hBlank", hBlank, 1);
    check(pixValid == 0, "R1", "pixValid", pixValid, 0);
    check(codeErr == 0, "R1", "codeErr", codeErr, 0);

    // R5: bytes outside active video are ignored.
    pixCount = 0;
    idle(4);
    sendGroups(2, 1);
    idle(2);
    check(pixCount == 0, "R5", "pixels while blanked", pixCount, 0);

    // R4 R5: a full line in field 0, eight luma samples.
    pixCount = 0;
    sendCode(8'h80);
    sendGroups(4, 3);
    sendCode(8'h9D);
    idle(2);
    check(pixCount == 8, "R5", "pixels per line", pixCount, 8);

    // R8: reserved bytes inside the line, field 1.
    pixCount = 0;
    sendCode(8'hC7);
    sendByte(8'h55); sendByte(8'h30); sendByte(8'h00); sendByte(8'h66);
    sendByte(8'hFF); sendByte(8'h31);
    sendByte(8'h00); sendByte(8'h57); sendByte(8'h32); sendByte(8'hFF);
    sendByte(8'h68); sendByte(8'h33);
    sendCode(8'hDA);
    idle(2);
    check(pixCount == 4, "R8", "pixels with reserved bytes", pixCount, 4);

    // R7: line ends after Cb and Y0; next line restarts at Cb.
    pixCount = 0;
    sendCode(8'h80);
    sendGroups(2, 9);
    sendByte(8'h77); sendByte(8'h44);
    sendCode(8'h9D);
    idle(2);
    check(pixCount == 4, "R7", "pixels on cut line", pixCount, 4);
    pixCount = 0;
    sendCode(8'h80);
    sendGroups(1, 20);
    sendCode(8'h9D);
    idle(2);
    check(pixCount == 2, "R7", "pixels after restart", pixCount, 2);

    // R6: start-of-active with vertical blanking set.
    pixCount = 0;
    sendCode(8'hAB);
    sendGroups(2, 5);
    sendCode(8'hB6);
    idle(2);
    check(pixCount == 0, "R6", "pixels in vblank", pixCount, 0);

    // R3: bad protection bits and a missing marker bit.
    errCount = 0;
    sendCode(8'h81);
    idle(2);
    sendCode(8'h47);
    idle(2);
    check(errCount == 2, "R3", "error pulses", errCount, 2);

    // R3: a bad code mid-line keeps the sample phase.
    pixCount = 0;
    errCount = 0;
    sendCode(8'h80);
    sendByte(8'h61); sendByte(8'h3A);
    sendCode(8'h85);
    sendByte(8'h92); sendByte(8'h3B);
    sendCode(8'h9D);
    idle(3);
    check(pixCount == 2, "R3", "pixels across bad code", pixCount, 2);
    check(errCount == 1, "R3", "error pulse mid-line", errCount, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule